// File: doc/BRIEF.md
# DMA Translation Table Walker

This block turns an inbound DMA address into a system address. A request carries the address, a read/write flag and a partition number that has already been resolved. The block classifies the address window first and rejects the message-signalled windows and all unsupported windows. For an address it can translate, it selects one of two validation entries that belong to the partition. It decodes that entry into a table base, a level count, a table size and a page size. It then fetches one 64-bit table entry per level through a memory read port until it reaches the final entry.

The result is a single-cycle response. It carries a status code, the translated page address, the page mask and the granted permissions. A page-size field of zero selects a bypass mapping, which needs no fetch. The validation entries are held in a small register table that the surrounding logic writes through a simple write port. Only one walk is in flight at a time.

Top module: `dma_xlate_walker`

## Requirements
- R1: Address bits 63..60 equal to 1 give status 1 (64-bit message window). Any value from 2 to 15 gives status 2 (unsupported). Neither case issues a memory fetch.
- R2: While `msi32_en` is 1, an address whose bits 63..16 equal 0xFFFF gives status 3 and is not fetched. While `msi32_en` is 0, the same address is translated normally.
- R3: The validation entry used is index `part*2 + addr[59]`.
- R4: Validation entry layout: bit 51 allows bypass, bits 47..12 hold the table base, bits 11..8 the level count, bits 7..4 the table-size field and bits 3..0 the page-size field. A page-size field of 0 with bit 51 set gives status 0, address `addr & 0x0003FFFFFFFFF000`, mask 0xFFF, permission 2'b11 and no fetch. With bit 51 clear it gives status 4.
- R5: A level count above `MAX_LVL` (default 4) gives status 4 with no fetch. Otherwise exactly level count + 1 entries are fetched, unless a fault stops the walk early.
- R6: The table shift is the table-size field + 8 and the page shift is the page-size field + 11. The first walk shift is table shift × level count + page shift, and it drops by the table shift at each level. Each fetch address is `base | (((addr >> shift) & ((1<<table shift)-1)) << 3)`.
- R7: Table entries are big-endian. The byte at the lowest address, carried on `mem_rdata[7:0]`, is the most significant byte, and lane k carries the byte at address + k. The next base is the entry with bits 11..0 cleared.
- R8: An intermediate entry whose bits 1..0 are both 0 ends the walk with status 5.
- R9: The final entry needs bit 1 for a write and bit 0 for a read, or the walk ends with status 6. On success the status is 0, the mask is `(1<<page shift)-1`, the address is the final entry with the mask bits cleared, and the permission is the final entry's bits 1..0.
- R10: A fetch answered with `mem_rerr` ends the walk with status 7.
- R11: `req_ready` is low from the accepting edge until the walk ends. `mem_req` is a one-cycle pulse and does not rise again before the matching response arrives. `rsp_valid` is a one-cycle pulse.
- R12: A validation-entry write in the cycle the walk decodes that entry does not affect that walk. The next walk uses the new value.
- R13: After reset, `req_ready` is 1, `rsp_valid` is 0, `mem_req` is 0 and every validation entry is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| msi32_en | input | 1 | Enables the 32-bit message window check |
| ve_wr_en | input | 1 | Validation entry write strobe |
| ve_wr_idx | input | PART_W+1 | Validation entry index to write |
| ve_wr_data | input | 64 | Validation entry value |
| req_valid | input | 1 | Translation request |
| req_ready | output | 1 | Walker idle, request accepted on this edge |
| req_addr | input | 64 | DMA address to translate |
| req_write | input | 1 | 1 for a write access |
| req_part | input | PART_W | Resolved partition number |
| mem_req | output | 1 | Table fetch request pulse |
| mem_addr | output | 64 | Table fetch address |
| mem_rvalid | input | 1 | Fetch response strobe |
| mem_rerr | input | 1 | Fetch response error |
| mem_rdata | input | 64 | Fetch data, lane k is byte at address + k |
| rsp_valid | output | 1 | Response pulse |
| rsp_status | output | 3 | 0 ok, 1 msi64, 2 unsupported, 3 msi32, 4 bad entry, 5 indirect, 6 permission, 7 fetch error |
| rsp_taddr | output | 64 | Translated page address |
| rsp_mask | output | 64 | Page offset mask |
| rsp_perm | output | 2 | Granted permission {write, read} |

## Verification
Two functions can land in the same cycle: the configuration path writing a validation entry, and the walk decoding that same entry. The bench provokes this by driving the write on the exact cycle after the request is accepted. It then expects the first walk to follow the old bypass entry and the next walk to report a bad entry from the new value. A second overlap comes from the memory responder: it varies its latency and watches `mem_req` during every wait, so a second fetch raised while a response is still pending is reported.

// File: rtl/dxw_pkg.sv
package dxw_pkg;

    localparam int ADDR_W     = 64;
    localparam int FLD_W      = 4;
    localparam int BASE_LSB   = 12;
    localparam int BASE_W     = 36;
    localparam int BYPASS_BIT = 51;
    localparam int SH_W       = 9;
    localparam int TS_BIAS    = 8;
    localparam int PS_BIAS    = 11;
    localparam logic [63:0] BYPASS_KEEP = 64'h0003_FFFF_FFFF_F000;
    localparam logic [63:0] PAGE4K_MASK = 64'h0000_0000_0000_0FFF;

    typedef enum logic [2:0] {
        ST_OK        = 3'd0,
        ST_MSI64     = 3'd1,
        ST_UNSUP     = 3'd2,
        ST_MSI32     = 3'd3,
        ST_BAD_ENTRY = 3'd4,
        ST_INDIRECT  = 3'd5,
        ST_PERM      = 3'd6,
        ST_FETCH     = 3'd7
    } xl_status_e;

    typedef enum logic [1:0] {
        RG_XLATE = 2'd0,
        RG_MSI64 = 2'd1,
        RG_UNSUP = 2'd2,
        RG_MSI32 = 2'd3
    } region_e;

    typedef enum logic [1:0] {
        W_IDLE   = 2'd0,
        W_DECODE = 2'd1,
        W_REQ    = 2'd2,
        W_WAIT   = 2'd3
    } wstate_e;

    typedef struct packed {
        logic              bypass_ok;
        logic [BASE_W-1:0] tbl_base;
        logic [FLD_W-1:0]  levels;
        logic [FLD_W-1:0]  tsize;
        logic [FLD_W-1:0]  psize;
    } ve_fields_t;

    function automatic ve_fields_t ve_decode(input logic [63:0] e);
        ve_fields_t f;
        f.bypass_ok = e[BYPASS_BIT];
        f.tbl_base  = e[BASE_LSB +: BASE_W];
        f.levels    = e[11:8];
        f.tsize     = e[7:4];
        f.psize     = e[3:0];
        return f;
    endfunction

    function automatic logic [63:0] swap64(input logic [63:0] d);
        logic [63:0] r;
        for (int i = 0; i < 8; i++) begin
            r[8*i +: 8] = d[8*(7-i) +: 8];
        end
        return r;
    endfunction

    function automatic logic [63:0] low_ones(input logic [SH_W-1:0] n);
        logic [63:0] r;
        r = '0;
        for (int i = 0; i < 64; i++) begin
            if (i < int'(n)) r[i] = 1'b1;
        end
        return r;
    endfunction

endpackage

// File: rtl/dxw_region_classify.sv
module dxw_region_classify
    import dxw_pkg::*;
(
    input  logic [63:0] addr,
    input  logic        msi32_en,
    output region_e     region
);

    logic msi32_hit;

    assign msi32_hit = msi32_en && (addr[63:16] == 48'h0000_0000_FFFF);

    always_comb begin
        unique case (addr[63:60])
            4'h0:    region = msi32_hit ? RG_MSI32 : RG_XLATE;
            4'h1:    region = RG_MSI64;
            default: region = RG_UNSUP;
        endcase
    end

endmodule

// File: rtl/dxw_entry_table.sv
module dxw_entry_table #(
    parameter int PART_W = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [PART_W:0]   wr_idx,
    input  logic [63:0]       wr_data,
    input  logic [PART_W:0]   rd_idx,
    output logic [63:0]       rd_data
);

    localparam int IDX_W = PART_W + 1;
    localparam int DEPTH = 1 << IDX_W;

    logic [DEPTH*64-1:0] flat;

    for (genvar g = 0; g < DEPTH; g++) begin : g_ent
        logic [63:0] q;
        always_ff @(posedge clk) begin
            if (rst) begin
                q <= '0;
            end else if (wr_en && (wr_idx == IDX_W'(g))) begin
                q <= wr_data;
            end
        end
        assign flat[g*64 +: 64] = q;
    end

    assign rd_data = flat[rd_idx*64 +: 64];

    AST_TABLE_HOLD: assert property (@(posedge clk) disable iff (rst)
        !wr_en |=> $stable(flat)); // R12

endmodule

// File: rtl/dxw_walk_fsm.sv
module dxw_walk_fsm
    import dxw_pkg::*;
#(
    parameter int PART_W  = 3,
    parameter int MAX_LVL = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [63:0]       req_addr,
    input  logic              req_write,
    input  logic [PART_W-1:0] req_part,
    output logic [63:0]       cur_addr,
    input  region_e           region,
    output logic [PART_W:0]   ent_idx,
    input  logic [63:0]       ent_data,
    output logic              mem_req,
    output logic [63:0]       mem_addr,
    input  logic              mem_rvalid,
    input  logic              mem_rerr,
    input  logic [63:0]       mem_rdata,
    output logic              rsp_valid,
    output xl_status_e        rsp_status,
    output logic [63:0]       rsp_taddr,
    output logic [63:0]       rsp_mask,
    output logic [1:0]        rsp_perm
);

    wstate_e             state;
    logic [63:0]         a_q;
    logic                wr_q;
    logic [PART_W-1:0]   part_q;
    logic [63:0]         base_q;
    logic [SH_W-1:0]     sh_q;
    logic [SH_W-1:0]     ts_q;
    logic [SH_W-1:0]     ps_q;
    logic [FLD_W-1:0]    rem_q;

    ve_fields_t          dec;
    logic [63:0]         ev;
    logic                perm_ok;
    logic [SH_W-1:0]     ts_init;
    logic [SH_W-1:0]     ps_init;
    logic [SH_W-1:0]     sh_init;
    logic                fin;
    xl_status_e          fin_st;
    logic [63:0]         fin_ta;
    logic [63:0]         fin_mk;
    logic [1:0]          fin_pm;

    assign cur_addr  = a_q;
    assign ent_idx   = {part_q, a_q[59]};
    assign req_ready = (state == W_IDLE);
    assign mem_req   = (state == W_REQ);
    assign mem_addr  = base_q | (((a_q >> sh_q) & low_ones(ts_q)) << 3);

    assign dec     = ve_decode(ent_data);
    assign ev      = swap64(mem_rdata);
    assign perm_ok = wr_q ? ev[1] : ev[0];
    assign ts_init = SH_W'(dec.tsize) + SH_W'(TS_BIAS);
    assign ps_init = SH_W'(dec.psize) + SH_W'(PS_BIAS);
    assign sh_init = ts_init * SH_W'(dec.levels) + ps_init;

    always_comb begin
        fin    = 1'b0;
        fin_st = ST_OK;
        fin_ta = '0;
        fin_mk = '0;
        fin_pm = '0;
        unique case (state)
            W_DECODE: begin
                unique case (region)
                    RG_MSI64: begin fin = 1'b1; fin_st = ST_MSI64; end
                    RG_UNSUP: begin fin = 1'b1; fin_st = ST_UNSUP; end
                    RG_MSI32: begin fin = 1'b1; fin_st = ST_MSI32; end
                    default: begin
                        if (32'(dec.levels) > MAX_LVL) begin
                            fin    = 1'b1;
                            fin_st = ST_BAD_ENTRY;
                        end else if (dec.psize == '0) begin
                            fin = 1'b1;
                            if (dec.bypass_ok) begin
                                fin_ta = a_q & BYPASS_KEEP;
                                fin_mk = PAGE4K_MASK;
                                fin_pm = 2'b11;
                            end else begin
                                fin_st = ST_BAD_ENTRY;
                            end
                        end
                    end
                endcase
            end
            W_WAIT: begin
                if (mem_rvalid) begin
                    if (mem_rerr) begin
                        fin    = 1'b1;
                        fin_st = ST_FETCH;
                    end else if (rem_q != '0) begin
                        if (ev[1:0] == 2'b00) begin
                            fin    = 1'b1;
                            fin_st = ST_INDIRECT;
                        end
                    end else begin
                        fin = 1'b1;
                        if (!perm_ok) begin
                            fin_st = ST_PERM;
                        end else begin
                            fin_mk = low_ones(ps_q);
                            fin_ta = ev & ~low_ones(ps_q);
                            fin_pm = ev[1:0];
                        end
                    end
                end
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state      <= W_IDLE;
            a_q        <= '0;
            wr_q       <= 1'b0;
            part_q     <= '0;
            base_q     <= '0;
            sh_q       <= '0;
            ts_q       <= '0;
            ps_q       <= '0;
            rem_q      <= '0;
            rsp_valid  <= 1'b0;
            rsp_status <= ST_OK;
            rsp_taddr  <= '0;
            rsp_mask   <= '0;
            rsp_perm   <= '0;
        end else begin
            rsp_valid <= 1'b0;
            if (fin) begin
                rsp_valid  <= 1'b1;
                rsp_status <= fin_st;
                rsp_taddr  <= fin_ta;
                rsp_mask   <= fin_mk;
                rsp_perm   <= fin_pm;
                state      <= W_IDLE;
            end else begin
                unique case (state)
                    W_IDLE: begin
                        if (req_valid) begin
                            a_q    <= req_addr;
                            wr_q   <= req_write;
                            part_q <= req_part;
                            state  <= W_DECODE;
                        end
                    end
                    W_DECODE: begin
                        base_q <= {16'h0, dec.tbl_base, 12'h000};
                        ts_q   <= ts_init;
                        ps_q   <= ps_init;
                        sh_q   <= sh_init;
                        rem_q  <= dec.levels;
                        state  <= W_REQ;
                    end
                    W_REQ: state <= W_WAIT;
                    W_WAIT: begin
                        if (mem_rvalid) begin
                            base_q <= ev & ~PAGE4K_MASK;
                            sh_q   <= sh_q - ts_q;
                            rem_q  <= rem_q - 1'b1;
                            state  <= W_REQ;
                        end
                    end
                    default: state <= W_IDLE;
                endcase
            end
        end
    end

    AST_SINGLE_FETCH: assert property (@(posedge clk) disable iff (rst)
        mem_req |=> !mem_req); // R11
    AST_RSP_PULSE: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |=> !rsp_valid); // R11
    AST_REJECT_NO_FETCH: assert property (@(posedge clk) disable iff (rst)
        (state == W_DECODE && region != RG_XLATE) |=> (rsp_valid && !mem_req)); // R1
    AST_OK_ALIGNED: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && rsp_status == ST_OK) |->
            (((rsp_taddr & rsp_mask) == 64'h0) && (((rsp_mask + 64'h1) & rsp_mask) == 64'h0))); // R9
    AST_WRITE_GRANTED: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && rsp_status == ST_OK && wr_q) |-> rsp_perm[1]); // R9

endmodule

// File: rtl/dma_xlate_walker.sv
module dma_xlate_walker
    import dxw_pkg::*;
#(
    parameter int PART_W  = 3,
    parameter int MAX_LVL = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              msi32_en,
    input  logic              ve_wr_en,
    input  logic [PART_W:0]   ve_wr_idx,
    input  logic [63:0]       ve_wr_data,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [63:0]       req_addr,
    input  logic              req_write,
    input  logic [PART_W-1:0] req_part,
    output logic              mem_req,
    output logic [63:0]       mem_addr,
    input  logic              mem_rvalid,
    input  logic              mem_rerr,
    input  logic [63:0]       mem_rdata,
    output logic              rsp_valid,
    output logic [2:0]        rsp_status,
    output logic [63:0]       rsp_taddr,
    output logic [63:0]       rsp_mask,
    output logic [1:0]        rsp_perm
);

    logic [63:0]     cur_addr;
    region_e         region;
    logic [PART_W:0] ent_idx;
    logic [63:0]     ent_data;
    xl_status_e      status_e;

    dxw_region_classify u_class (
        .addr     (cur_addr),
        .msi32_en (msi32_en),
        .region   (region)
    );

    dxw_entry_table #(.PART_W(PART_W)) u_table (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (ve_wr_en),
        .wr_idx  (ve_wr_idx),
        .wr_data (ve_wr_data),
        .rd_idx  (ent_idx),
        .rd_data (ent_data)
    );

    dxw_walk_fsm #(.PART_W(PART_W), .MAX_LVL(MAX_LVL)) u_walk (
        .clk        (clk),
        .rst        (rst),
        .req_valid  (req_valid),
        .req_ready  (req_ready),
        .req_addr   (req_addr),
        .req_write  (req_write),
        .req_part   (req_part),
        .cur_addr   (cur_addr),
        .region     (region),
        .ent_idx    (ent_idx),
        .ent_data   (ent_data),
        .mem_req    (mem_req),
        .mem_addr   (mem_addr),
        .mem_rvalid (mem_rvalid),
        .mem_rerr   (mem_rerr),
        .mem_rdata  (mem_rdata),
        .rsp_valid  (rsp_valid),
        .rsp_status (status_e),
        .rsp_taddr  (rsp_taddr),
        .rsp_mask   (rsp_mask),
        .rsp_perm   (rsp_perm)
    );

    assign rsp_status = status_e;

endmodule

// File: tb/test_dma_xlate_walker.sv
module test_dma_xlate_walker;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        msi32_en = 1'b0;
    logic        ve_wr_en = 1'b0;
    logic [3:0]  ve_wr_idx = '0;
    logic [63:0] ve_wr_data = '0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [63:0] req_addr = '0;
    logic        req_write = 1'b0;
    logic [2:0]  req_part = '0;
    logic        mem_req;
    logic [63:0] mem_addr;
    logic        mem_rvalid = 1'b0;
    logic        mem_rerr = 1'b0;
    logic [63:0] mem_rdata = '0;
    logic        rsp_valid;
    logic [2:0]  rsp_status;
    logic [63:0] rsp_taddr;
    logic [63:0] rsp_mask;
    logic [1:0]  rsp_perm;

    int errors = 0;
    int checks = 0;
    int fetch_cnt = 0;
    int overlap_err = 0;
    logic [63:0] first_fa;

    logic [63:0] bmem [logic [63:0]];
    bit          errset [logic [63:0]];
    logic [63:0] ent_m [16];
    logic [63:0] chain_fa [16];

    always #10 clk = ~clk;

    dma_xlate_walker i_dma_xlate_walker (
        .clk(clk), .rst(rst), .msi32_en(msi32_en),
        .ve_wr_en(ve_wr_en), .ve_wr_idx(ve_wr_idx), .ve_wr_data(ve_wr_data),
        .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
        .req_write(req_write), .req_part(req_part),
        .mem_req(mem_req), .mem_addr(mem_addr), .mem_rvalid(mem_rvalid),
        .mem_rerr(mem_rerr), .mem_rdata(mem_rdata),
        .rsp_valid(rsp_valid), .rsp_status(rsp_status), .rsp_taddr(rsp_taddr),
        .rsp_mask(rsp_mask), .rsp_perm(rsp_perm)
    );

    function automatic logic [63:0] to_lanes(input logic [63:0] v);
        logic [63:0] r;
        for (int i = 0; i < 8; i++) r[8*i +: 8] = v[8*(7-i) +: 8];
        return r;
    endfunction

    function automatic logic [63:0] mk_entry(input logic [63:0] base, input int lev,
                                             input int ts, input int ps, input bit byp);
        return (64'(byp) << 51) | (base & 64'h0000_FFFF_FFFF_F000) |
               (64'(lev & 15) << 8) | (64'(ts & 15) << 4) | 64'(ps & 15);
    endfunction

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    task automatic check(input bit ok, input string tag, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    // memory responder: lane k = byte at address + k, value stored big-endian
    initial begin
        forever begin
            if (mem_req) begin
                logic [63:0] fa;
                int lat;
                fa = mem_addr;
                if (fetch_cnt == 0) first_fa = fa;
                fetch_cnt++;
                lat = 1 + (fetch_cnt % 3);
                for (int k = 0; k < lat; k++) begin
                    @(negedge clk);
                    if (mem_req) overlap_err++;
                end
                mem_rvalid = 1'b1;
                mem_rerr   = errset.exists(fa >> 3);
                mem_rdata  = to_lanes(bmem.exists(fa >> 3) ? bmem[fa >> 3] : 64'h0);
                @(negedge clk);
                mem_rvalid = 1'b0;
                mem_rerr   = 1'b0;
            end else begin
                @(negedge clk);
            end
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual hung expected finished");
        summary();
    end

    task automatic set_entry(input int idx, input logic [63:0] v);
        @(negedge clk);
        ve_wr_en = 1'b1; ve_wr_idx = 4'(idx); ve_wr_data = v;
        @(negedge clk);
        ve_wr_en = 1'b0;
        ent_m[idx] = v;
    endtask

    task automatic ref_walk(input logic [63:0] a, input logic w, input logic [2:0] p,
                            output logic [2:0] st, output logic [63:0] ta,
                            output logic [63:0] mk, output logic [1:0] pm, output int nf);
        logic [63:0] e, base, v, fa;
        int lev, ts, ps, sh;
        st = 0; ta = 0; mk = 0; pm = 0; nf = 0;
        if (a[63:60] == 4'h1) begin st = 1; return; end
        if (a[63:60] != 4'h0) begin st = 2; return; end
        if (msi32_en && a[63:16] == 48'hFFFF) begin st = 3; return; end
        e = ent_m[{p, a[59]}];
        lev = int'(e[11:8]); ts = int'(e[7:4]) + 8; ps = int'(e[3:0]) + 11;
        if (lev > 4) begin st = 4; return; end
        if (e[3:0] == 4'h0) begin
            if (e[51]) begin ta = a & 64'h0003_FFFF_FFFF_F000; mk = 64'hFFF; pm = 2'b11; end
            else st = 4;
            return;
        end
        base = e & 64'h0000_FFFF_FFFF_F000;
        sh = ts * lev + ps;
        for (int i = 0; i <= lev; i++) begin
            fa = base | (((a >> sh) & ((64'd1 << ts) - 1)) << 3);
            nf++;
            if (errset.exists(fa >> 3)) begin st = 7; return; end
            v = bmem.exists(fa >> 3) ? bmem[fa >> 3] : 64'h0;
            if (i < lev) begin
                if (v[1:0] == 2'b00) begin st = 5; return; end
                base = v & ~64'hFFF;
                sh -= ts;
            end else begin
                if (w ? !v[1] : !v[0]) begin st = 6; return; end
                mk = (64'd1 << ps) - 1;
                ta = v & ~mk;
                pm = v[1:0];
            end
        end
    endtask

    task automatic build_chain(input logic [63:0] a, input logic [2:0] p, input logic [63:0] fv);
        logic [63:0] e, base, nb, fa;
        int lev, ts, ps, sh;
        e = ent_m[{p, a[59]}];
        lev = int'(e[11:8]); ts = int'(e[7:4]) + 8; ps = int'(e[3:0]) + 11;
        base = e & 64'h0000_FFFF_FFFF_F000;
        sh = ts * lev + ps;
        for (int i = 0; i <= lev; i++) begin
            fa = base | (((a >> sh) & ((64'd1 << ts) - 1)) << 3);
            chain_fa[i] = fa;
            if (i < lev) begin
                nb = 64'h0040_0000 + (64'(i) << 16);
                bmem[fa >> 3] = nb | 64'h1;
                base = nb;
                sh -= ts;
            end else begin
                bmem[fa >> 3] = fv;
            end
        end
    endtask

    task automatic walk(input logic [63:0] a, input logic w, input logic [2:0] p,
                        input string tag, input bit do_wr = 0, input int wr_idx = 0,
                        input logic [63:0] wr_val = 64'h0);
        logic [2:0] est; logic [63:0] eta, emk; logic [1:0] epm; int enf;
        int k;
        ref_walk(a, w, p, est, eta, emk, epm, enf);
        fetch_cnt = 0;
        @(negedge clk);
        req_valid = 1'b1; req_addr = a; req_write = w; req_part = p;
        @(negedge clk);
        req_valid = 1'b0;
        check(req_ready == 1'b0, "R11", "ready while busy", 64'(req_ready), 64'h0);
        if (do_wr) begin
            ve_wr_en = 1'b1; ve_wr_idx = 4'(wr_idx); ve_wr_data = wr_val;
        end
        k = 0;
        while (!rsp_valid && k < 2000) begin
            @(negedge clk);
            ve_wr_en = 1'b0;
            k++;
        end
        ve_wr_en = 1'b0;
        if (do_wr) ent_m[wr_idx] = wr_val;
        checks++;
        if (!rsp_valid || rsp_status !== est || rsp_taddr !== eta || rsp_mask !== emk ||
            rsp_perm !== epm || fetch_cnt != enf) begin
            errors++;
            $display("FAIL %s: status %0d/%0d taddr %h/%h mask %h/%h perm %0d/%0d fetches %0d/%0d (actual/expected)",
                     tag, rsp_status, est, rsp_taddr, eta, rsp_mask, emk, rsp_perm, epm, fetch_cnt, enf);
        end
        @(negedge clk);
    endtask

    initial begin
        logic [63:0] a, fv;
        for (int i = 0; i < 16; i++) ent_m[i] = 64'h0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R13 reset state
        check(req_ready == 1'b1, "R13", "req_ready", 64'(req_ready), 64'h1);
        check(rsp_valid == 1'b0, "R13", "rsp_valid", 64'(rsp_valid), 64'h0);
        check(mem_req == 1'b0, "R13", "mem_req", 64'(mem_req), 64'h0);
        walk(64'h0000_0000_1234_5000, 1'b0, 3'd0, "R13 zero entry is bad");

        // R1 region sweep over bits 63..60, R4 bypass in window 0
        set_entry(0, mk_entry(64'h0, 0, 0, 0, 1));
        for (int n = 0; n < 16; n++)
            walk({4'(n), 60'h0AB_CDEF_1234_5678} & 64'hF7FF_FFFF_FFFF_FFFF, 1'b1, 3'd0, "R1 R4 region");

        // R2 32-bit message window
        msi32_en = 1'b1;
        walk(64'h0000_0000_FFFF_1234, 1'b0, 3'd0, "R2 msi32 hit");
        walk(64'h0000_0000_FFFE_1234, 1'b0, 3'd0, "R2 msi32 neighbour");
        msi32_en = 1'b0;
        walk(64'h0000_0000_FFFF_1234, 1'b0, 3'd0, "R2 msi32 disabled");

        // R4 bypass without permission bit
        set_entry(0, mk_entry(64'h0, 0, 0, 0, 0));
        walk(64'h0000_0123_4567_8000, 1'b0, 3'd0, "R4 bypass not allowed");

        // R3 entry selection sweep, single level, distinct tables
        for (int k = 0; k < 16; k++)
            set_entry(k, mk_entry(64'h0010_0000 * (k + 1), 0, 0, 1, 0));
        for (int k = 0; k < 16; k++) begin
            a = (64'(k & 1) << 59) | (64'(k) << 13) | 64'h0000_0000_0000_0ABC;
            build_chain(a, 3'(k >> 1), (64'h0100_0000 * (k + 1)) | 64'h3);
            walk(a, 1'b0, 3'(k >> 1), "R3 entry select");
        end

        // R5 R6 R7 R9 level, table and page sweep
        for (int lev = 0; lev <= 4; lev++)
            for (int ts = 0; ts <= 1; ts++)
                for (int ps = 1; ps <= 3; ps++) begin
                    set_entry(0, mk_entry(64'h0030_0000, lev, ts, ps, 0));
                    a = {$urandom, $urandom} & 64'h07FF_FFFF_FFFF_FFFF;
                    fv = ({$urandom, $urandom} & 64'h0000_FFFF_FFFF_F000) | 64'h3;
                    build_chain(a, 3'd0, fv);
                    walk(a, 1'($urandom & 1), 3'd0, "R5 R6 R7 R9 walk");
                    check(first_fa == chain_fa[0], "R6", "first fetch address", first_fa, chain_fa[0]);
                end

        // R5 level count above maximum
        for (int lev = 5; lev <= 15; lev += 5) begin
            set_entry(0, mk_entry(64'h0030_0000, lev, 0, 1, 0));
            walk(64'h0000_0000_0012_3000, 1'b0, 3'd0, "R5 too many levels");
        end

        // R8 invalid intermediate entry
        set_entry(0, mk_entry(64'h0030_0000, 2, 0, 1, 0));
        a = 64'h0000_0012_3456_7000;
        build_chain(a, 3'd0, 64'h0000_5555_0000_0003);
        bmem[chain_fa[1] >> 3] = 64'h0000_0000_0077_7000;
        walk(a, 1'b0, 3'd0, "R8 indirect fault");
        bmem[chain_fa[1] >> 3] = 64'h0000_0000_0077_7002;
        bmem[64'h0000_0000_0077_7000 >> 3] = 64'h0;
        build_chain(a, 3'd0, 64'h0000_5555_0000_0003);

        // R9 permission sweep
        for (int pm = 0; pm < 4; pm++)
            for (int w = 0; w < 2; w++) begin
                build_chain(a, 3'd0, 64'h0000_4444_4444_4000 | 64'(pm));
                walk(a, 1'(w), 3'd0, "R9 permission");
            end

        // R10 fetch error at the middle level
        build_chain(a, 3'd0, 64'h0000_4444_4444_4003);
        errset[chain_fa[1] >> 3] = 1'b1;
        walk(a, 1'b0, 3'd0, "R10 fetch error");
        errset.delete(chain_fa[1] >> 3);
        walk(a, 1'b0, 3'd0, "R10 recovery");

        // R12 entry write in the decode cycle of the same walk
        set_entry(10, mk_entry(64'h0, 0, 0, 0, 1));
        walk(64'h0000_0ABC_DEF0_1234, 1'b0, 3'd5, "R12 old entry used", 1'b1, 10,
             mk_entry(64'h0, 0, 0, 0, 0));
        walk(64'h0000_0ABC_DEF0_1234, 1'b0, 3'd5, "R12 new entry used");

        check(overlap_err == 0, "R11", "overlapping fetches", 64'(overlap_err), 64'h0);
        summary();
    end

endmodule